// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a two-wire slave port that gives an external master read and write access to a small bank of byte-wide control registers. The master raises a select line to open a transfer. It then pulses a configuration clock and moves bits over a single bidirectional data line. The port runs entirely in the system clock domain. The select, clock and data inputs pass through synchronisers, and the configuration clock is oversampled to find its rising edges.

Every transfer opens with a command byte that gives the direction and the starting register. In a write transfer, the bytes that follow are shifted in, and each completed byte goes straight into the addressed register. In a read transfer, the port sources the register bits onto the data line and raises its output enable so that the pad can drive the line. In both directions the register index steps forward after every data byte, so one select period can cover several registers. The whole bank is brought out as a flat vector for the logic the registers control.

Top module: `cfg_serial_port`

## Requirements
- R1: While select is low, the data output enable stays low and configuration clock pulses leave every register unchanged.
- R2: The first byte after select rises is a command. Bit 7 is 1 for read and 0 for write. Bits 2:0 hold the starting register index. Bits 6:3 are ignored.
- R3: In a write, one data bit is taken at each rising configuration clock edge, most significant bit first. After the eighth bit, the byte is stored in the indexed register, and no other register changes.
- R4: After each data byte, read or write, the register index advances by one and wraps from 7 to 0.
- R5: In a read, the next register bit, most significant first, is driven at each rising configuration clock edge. It holds steady until the following rising edge, so it is valid at the falling edge.
- R6: The output enable is high only during the data phase of a read with select high. It is low during the command byte, during writes, and within a few system cycles of select falling.
- R7: Dropping select discards any partial byte. The next select period starts again with a command byte.
- R8: A synchronous system reset clears all registers to zero and drops the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Port select from the master, active high, asynchronous |
| sclk_i | input | 1 | Configuration clock from the master, asynchronous |
| sdat_i | input | 1 | Data line as seen by the port (pad input) |
| sdat_o | output | 1 | Read data bit sourced toward the pad |
| sdat_oe | output | 1 | Pad drive enable for the data line |
| regs_o | output | REG_COUNT*DATA_W | Register bank, register n at bits n*DATA_W upward |

## Verification
A single-register write, a burst write that runs past the top index, and a command byte with junk in its unused bits show that storage, index wrap and command decode work independently. Burst reads compare each serially received byte against the values written before it. They also show that the output enable separates the command phase from the data phase. Clock pulses with select low, and a frame cut off in mid-byte followed by a fresh command, show that an inactive or abandoned transfer cannot touch the bank or confuse the next one.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
   typedef enum logic [1:0] {
      PH_CMD   = 2'd0,
      PH_WRITE = 2'd1,
      PH_READ  = 2'd2
   } cfg_phase_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfg_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cfg_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= '0;
               else     chain[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= '0;
               else     chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfg_edge_det.sv
module cfg_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= 1'b0;
      else     lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
   parameter int REG_COUNT = 8,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(REG_COUNT)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [DATA_W-1:0]           rd_data,
   output logic [REG_COUNT*DATA_W-1:0] flat_o
);
   logic [DATA_W-1:0] bank [REG_COUNT];

   generate
      for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)
               bank[r] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(r)))
               bank[r] <= wr_data;
         end
         assign flat_o[r*DATA_W +: DATA_W] = bank[r];
      end
   endgenerate

   assign rd_data = bank[rd_idx];
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfg_serial_pkg::*;
#(
   parameter int REG_COUNT   = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        sel_i,
   input  logic                        sclk_i,
   input  logic                        sdat_i,
   output logic                        sdat_o,
   output logic                        sdat_oe,
   output logic [REG_COUNT*DATA_W-1:0] regs_o
);
   localparam int IDX_W = $clog2(REG_COUNT);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (REG_COUNT < 2 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_count
         $error("cfg_serial_port: REG_COUNT must be a power of two, at least 2");
      end
      if (DATA_W < 4 || IDX_W > DATA_W - 1) begin : g_bad_width
         $error("cfg_serial_port: DATA_W too small for command layout");
      end
   endgenerate

   // synchronised inputs: {select, clock, data}
   logic [2:0] sync_q;
   logic       sel_s, sclk_s, sdat_s, sclk_rise;

   cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i ({sel_i, sclk_i, sdat_i}),
      .q_o (sync_q)
   );
   assign {sel_s, sclk_s, sdat_s} = sync_q;

   cfg_edge_det u_edge (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (sclk_s),
      .rise_o (sclk_rise)
   );

   cfg_phase_e        phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-2:0] shreg;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] byte_in, rd_data;
   logic              byte_last, wr_en, rd_bit;

   assign byte_in   = {shreg, sdat_s};
   assign byte_last = (bit_cnt == LAST_BIT);
   assign wr_en     = sel_s && sclk_rise && (phase == PH_WRITE) && byte_last;
   assign rd_bit    = rd_data[LAST_BIT - bit_cnt];

   cfg_regbank #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_idx  (idx),
      .wr_data (byte_in),
      .rd_idx  (idx),
      .rd_data (rd_data),
      .flat_o  (regs_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= PH_CMD;
         bit_cnt <= '0;
         shreg   <= '0;
         idx     <= '0;
         sdat_o  <= 1'b0;
         sdat_oe <= 1'b0;
      end else if (!sel_s) begin
         phase   <= PH_CMD;
         bit_cnt <= '0;
         shreg   <= '0;
         sdat_o  <= 1'b0;
         sdat_oe <= 1'b0;
      end else if (sclk_rise) begin
         bit_cnt <= byte_last ? '0 : bit_cnt + 1'b1;
         case (phase)
            PH_CMD: begin
               shreg <= byte_in[DATA_W-2:0];
               if (byte_last) begin
                  idx   <= byte_in[IDX_W-1:0];
                  phase <= byte_in[DATA_W-1] ? PH_READ : PH_WRITE;
               end
            end
            PH_WRITE: begin
               shreg <= byte_in[DATA_W-2:0];
               if (byte_last) idx <= idx + 1'b1;
            end
            PH_READ: begin
               sdat_o  <= rd_bit;
               sdat_oe <= 1'b1;
               if (byte_last) idx <= idx + 1'b1;
            end
            default: phase <= PH_CMD;
         endcase
      end
   end
endmodule

module cfg_serial_port_chk #(
   parameter int REGS_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              sel_s,
   input logic              sclk_rise,
   input logic [1:0]        phase,
   input logic              sdat_o,
   input logic              sdat_oe,
   input logic [REGS_W-1:0] regs_o
);
   AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (rst)
      !sel_s |=> !sdat_oe);                                            // R1
   AST_IDLE_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
      !sel_s |=> $stable(regs_o));                                     // R1
   AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
      sdat_oe |-> (phase == 2'd2));                                    // R6
   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (sel_s && sdat_oe && !sclk_rise) |=> $stable(sdat_o));           // R5
   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (regs_o == '0 && !sdat_oe));                      // R8
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.REGS_W(REG_COUNT*DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .sel_s     (sel_s),
   .sclk_rise (sclk_rise),
   .phase     (phase),
   .sdat_o    (sdat_o),
   .sdat_oe   (sdat_oe),
   .regs_o    (regs_o)
);

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;
   localparam int HP = 6;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sel_i = 1'b0, sclk_i = 1'b0, sdat_i = 1'b0;
   logic        sdat_o, sdat_oe;
   logic [63:0] regs_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] act_q[$];

   always #4 clk = ~clk;

   cfg_serial_port u_dut (
      .clk(clk), .rst(rst), .sel_i(sel_i), .sclk_i(sclk_i), .sdat_i(sdat_i),
      .sdat_o(sdat_o), .sdat_oe(sdat_oe), .regs_o(regs_o)
   );

   function automatic logic [7:0] reg_at(int i);
      return regs_o[i*8 +: 8];
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic waitc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(logic b);
      sdat_i = b; waitc(HP);
      sclk_i = 1'b1; waitc(HP);
      sclk_i = 1'b0;
   endtask

   task automatic send_byte(logic [7:0] b);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      waitc(HP);
   endtask

   task automatic get_byte(string tag);
      logic [7:0] v;
      for (int i = 7; i >= 0; i--) begin
         sclk_i = 1'b1; waitc(HP);
         v[i] = sdat_o;
         check({tag, " R6 oe during read"}, 64'(sdat_oe), 64'd1);
         sclk_i = 1'b0; waitc(HP);
      end
      act_q.push_back(v);
   endtask

   task automatic expect_byte(logic [7:0] v, string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic sel_on();  sel_i = 1'b1; waitc(HP); endtask
   task automatic sel_off(); sel_i = 1'b0; waitc(2*HP); endtask

   task automatic finish_up();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() > 0) begin
            logic [7:0] a;
            a = act_q.pop_front();
            if (exp_q.size() == 0) begin
               check("R5 unexpected read byte", 64'(a), 64'hx);
            end else begin
               check(tag_q.pop_front(), 64'(a), 64'(exp_q.pop_front()));
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   initial begin
      waitc(5);
      rst = 1'b0;
      waitc(2);
      check("R8 regs after reset", regs_o, 64'h0);
      check("R8 oe after reset", 64'(sdat_oe), 64'd0);

      // single write to register 2
      sel_on(); send_byte(8'h02);
      check("R6 oe low in command", 64'(sdat_oe), 64'd0);
      send_byte(8'hA5);
      check("R6 oe low in write", 64'(sdat_oe), 64'd0);
      sel_off();
      check("R3 single write", regs_o, 64'h0000_0000_00A5_0000);

      // burst write from 6, wrapping to 0
      sel_on(); send_byte(8'h06); send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); sel_off();
      check("R4 burst reg6", 64'(reg_at(6)), 64'h11);
      check("R4 burst reg7", 64'(reg_at(7)), 64'h22);
      check("R4 burst wrap reg0", 64'(reg_at(0)), 64'h33);

      // junk in bits 6:3 of a write command to register 2
      sel_on(); send_byte(8'h7A); send_byte(8'h5C); sel_off();
      check("R2 junk bits ignored reg2", 64'(reg_at(2)), 64'h5C);
      check("R2 no stray write reg3", 64'(reg_at(3)), 64'h00);

      // burst read from 6
      sel_on(); send_byte(8'h86);
      check("R6 oe low during read command", 64'(sdat_oe), 64'd0);
      expect_byte(8'h11, "R5 read reg6");
      expect_byte(8'h22, "R4 read reg7");
      expect_byte(8'h33, "R4 read wrap reg0");
      get_byte("R5"); get_byte("R4"); get_byte("R4");
      sel_off();
      check("R6 oe released after select", 64'(sdat_oe), 64'd0);

      // clock pulses with select low
      send_byte(8'h01); send_byte(8'hFF);
      check("R1 idle pulses reg1", 64'(reg_at(1)), 64'h00);
      check("R1 oe idle", 64'(sdat_oe), 64'd0);

      // abandoned partial byte, then fresh command
      sel_on(); send_byte(8'h03);
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      waitc(HP);
      sel_off();
      check("R7 partial byte dropped", 64'(reg_at(3)), 64'h00);
      sel_on(); send_byte(8'h04); send_byte(8'h99); sel_off();
      check("R7 new command after abort", 64'(reg_at(4)), 64'h99);
      check("R7 reg3 untouched", 64'(reg_at(3)), 64'h00);

      // single reads, alternating patterns
      sel_on(); send_byte(8'h05); send_byte(8'h96); sel_off();
      sel_on(); send_byte(8'h82);
      expect_byte(8'h5C, "R5 read reg2");
      get_byte("R5"); sel_off();
      sel_on(); send_byte(8'hFD);
      expect_byte(8'h96, "R2 read with junk bits reg5");
      get_byte("R2"); sel_off();

      waitc(4);
      check("R5 scoreboard drained", 64'(exp_q.size()), 64'd0);
      done = 1;
      finish_up();
   end
endmodule